// File: doc/BRIEF.md
# Multiple-Valued Diagonal Cross-Point Fabric

This block is a digital model of a small two-dimensional array of cells linked by X-shaped cross points. Every cell sits between four cross points, one at each diagonal corner. Each cross point is shared by up to four cells, so any cell can reach all eight of its neighbours through just four corners. Each value that moves through the fabric is a level from 0 to 3, carried on a 2-bit code.

A cell offers its source level to any subset of its four corners through drive switches. Each cross point adds the levels from its enabled drivers. A cell collects the levels of any subset of its corners through read switches, and adds them as well. One intersection can therefore carry three kinds of traffic:
- a plain quaternary value from one sender;
- two binary words packed as weights 1 and 2, which gives a two-bit value;
- the arithmetic sum of two binary words.

When two addends arrive at different corners of the same receiver, the receiver's read stage forms the sum. Any sum above 3 is clamped to 3 and flagged.

All switch enables are loaded through a serial shift chain while the load strobe is high. The enables stay fixed while the fabric runs. Outputs are registered and follow the source levels one clock later.

Top module: `xnet_fabric`

## Requirements
- R1: While rst_n is low at a clock edge, every output goes to 0 and every switch enable is cleared. After reset, the fabric therefore delivers 0 on every output until enables are loaded.
- R2: While cfg_en is high, each clock shifts cfg_din into bit 0 of the configuration vector, and every bit moves up by one. After NCELL*8 shifts, the first bit sent sits in the top bit. Cell n owns bits [n*8+3:n*8] as drive enables and bits [n*8+7:n*8+4] as read enables. During any cycle with cfg_en high, all switches count as open, so all outputs are 0 on the next cycle. While cfg_en is low, the configuration does not change.
- R3: Cell n sits at row n/COLS and column n%COLS. Its corner enable bit 0 is north-west, bit 1 is north-east, bit 2 is south-west and bit 3 is south-east. These map to cross point (r,c), (r,c+1), (r+1,c) and (r+1,c+1) respectively. Cross point (i,j) has index i*(COLS+1)+j in xp_lvl and xp_ovf.
- R4: A cross point with exactly one enabled driver outputs that driver's level, 0 to 3, unchanged.
- R5: Two drivers at levels 0/1 and 0/2 at one cross point give the packed value 0 to 3.
- R6: Two drivers at levels 0/1 each at one cross point give their sum 0, 1 or 2.
- R7: A cross point outputs the sum of its enabled drivers' levels, clamped to 3. xp_ovf is 1 exactly when that sum exceeds 3.
- R8: A cell whose drive enable for a corner is 0 adds nothing to that cross point, whatever its source level.
- R9: A cell's rx_lvl is the sum of the clamped levels of its read-enabled corners, clamped to 3. rx_ovf is 1 exactly when that sum exceeds 3. A cell with no read enable receives 0.
- R10: A transfer to the right-hand neighbour works as follows: the sender drives its north-east corner, and the receiver reads the same cross point as its north-west corner.
- R11: xp_lvl, xp_ovf, rx_lvl and rx_ovf reflect the src_lvl value and configuration present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_en | input | 1 | Configuration shift strobe; switches open while high |
| cfg_din | input | 1 | Serial configuration bit |
| src_lvl | input | NCELL*2 (18) | Source level of each cell, cell n at [2n+1:2n] |
| xp_lvl | output | NXP*2 (32) | Clamped level at each cross point |
| xp_ovf | output | NXP (16) | Cross-point sum exceeded 3 |
| rx_lvl | output | NCELL*2 (18) | Level received by each cell |
| rx_ovf | output | NCELL (9) | Received sum exceeded 3 |

## Verification
The assertions assume three things about the inputs:
- cfg_en is never high during the cycles whose outputs are being checked for data;
- rst_n is applied synchronously;
- src_lvl may take any 2-bit value, since every code is a legal level.

The bench drives all inputs on the falling edge and loads enables only through a whole shift burst. Outputs are compared only after cfg_en has been low for at least one edge, except in the checks that confirm the outputs fall to 0 during a load. Directed scenarios cover exact sums of 3 and 4 and lone drivers. Random configurations then exercise every corner mapping against a reference sum.

// File: rtl/xnet_pkg.sv
// Shared constants and types for the diagonal cross-point fabric.
// Assumes levels are non-negative integers no larger than LVL_MAX.
package xnet_pkg;
    localparam int LVL_W     = 2;
    localparam int LVL_MAX   = 3;
    localparam int NCORNER   = 4;
    localparam int CFG_PER   = 2 * NCORNER;

    // Corner positions within a cell's enable nibble
    localparam int CORNER_NW = 0;
    localparam int CORNER_NE = 1;
    localparam int CORNER_SW = 2;
    localparam int CORNER_SE = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic [NCORNER-1:0] rd;
        logic [NCORNER-1:0] drv;
    } cell_cfg_t;
endpackage

// File: rtl/xnet_cfg_chain.sv
// Serial configuration register: shifts din in at bit 0 while shift_en is high,
// holds otherwise. Assumes shift_en is synchronous to clk.
module xnet_cfg_chain #(
    parameter int WIDTH = 72
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    // Shift or hold the chain; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[WIDTH-2:0], din};
    end
endmodule

// File: rtl/xnet_sat_adder.sv
// Saturating multi-input level adder: sums the levels whose enable is set,
// clamps the result to LVL_MAX and flags any excess. Purely combinational.
// Assumes each input level is a valid 2-bit code.
module xnet_sat_adder
    import xnet_pkg::*;
#(
    parameter int NIN = 4
) (
    input  logic [NIN*LVL_W-1:0] lvl_in,
    input  logic [NIN-1:0]       en_in,
    output lvl_t                 lvl_out,
    output logic                 ovf_out
);
    localparam int SUM_W = $clog2(NIN * LVL_MAX + 1);

    logic [SUM_W-1:0] raw;

    // Accumulate the enabled levels
    always_comb begin
        raw = '0;
        for (int i = 0; i < NIN; i++) begin
            if (en_in[i]) raw = raw + SUM_W'(lvl_in[i*LVL_W +: LVL_W]);
        end
    end

    // Clamp and flag
    always_comb begin
        ovf_out = (raw > SUM_W'(LVL_MAX));
        lvl_out = ovf_out ? lvl_t'(LVL_MAX) : raw[LVL_W-1:0];
    end
endmodule

// File: rtl/xnet_fabric.sv
// Grid of ROWS x COLS cells joined at (ROWS+1) x (COLS+1) diagonal cross points.
// Each cross point sums the levels of the enabled drivers among its up to four
// neighbouring cells; each cell sums the levels of its read-enabled corners.
// Switch enables come from a serial chain and are treated as open while it loads.
// Outputs are registered, one cycle after the source levels.
module xnet_fabric
    import xnet_pkg::*;
#(
    parameter int ROWS = 3,
    parameter int COLS = 3,
    localparam int NCELL = ROWS * COLS,
    localparam int NXP   = (ROWS + 1) * (COLS + 1),
    localparam int CFG_W = NCELL * CFG_PER
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic                 cfg_din,
    input  logic [NCELL*LVL_W-1:0] src_lvl,
    output logic [NXP*LVL_W-1:0] xp_lvl,
    output logic [NXP-1:0]       xp_ovf,
    output logic [NCELL*LVL_W-1:0] rx_lvl,
    output logic [NCELL-1:0]     rx_ovf
);
    localparam int XCOLS = COLS + 1;

    logic [CFG_W-1:0]         cfg_q;
    logic [NXP*LVL_W-1:0]     xp_lvl_c;
    logic [NXP-1:0]           xp_ovf_c;
    logic [NCELL*LVL_W-1:0]   rx_lvl_c;
    logic [NCELL-1:0]         rx_ovf_c;

    xnet_cfg_chain #(.WIDTH(CFG_W)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .q        (cfg_q)
    );

    // Cross points: slot k picks neighbour cell (i-1+k/2, j-1+k%2) through its
    // corner 3-k (SE, SW, NE, NW of that cell respectively).
    for (genvar i = 0; i <= ROWS; i++) begin : g_xrow
        for (genvar j = 0; j <= COLS; j++) begin : g_xcol
            logic [NCORNER*LVL_W-1:0] slot_lvl;
            logic [NCORNER-1:0]       slot_en;
            for (genvar k = 0; k < NCORNER; k++) begin : g_slot
                localparam int RR = i - 1 + (k / 2);
                localparam int CC = j - 1 + (k % 2);
                if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
                    localparam int CELL = RR * COLS + CC;
                    assign slot_lvl[k*LVL_W +: LVL_W] = src_lvl[CELL*LVL_W +: LVL_W];
                    assign slot_en[k] = cfg_q[CELL*CFG_PER + (NCORNER - 1 - k)] & ~cfg_en;
                end else begin : g_edge
                    assign slot_lvl[k*LVL_W +: LVL_W] = '0;
                    assign slot_en[k] = 1'b0;
                end
            end
            xnet_sat_adder #(.NIN(NCORNER)) u_xp (
                .lvl_in  (slot_lvl),
                .en_in   (slot_en),
                .lvl_out (xp_lvl_c[(i*XCOLS+j)*LVL_W +: LVL_W]),
                .ovf_out (xp_ovf_c[i*XCOLS+j])
            );
        end
    end

    // Cell read stage: adds the levels of read-enabled corners
    for (genvar r = 0; r < ROWS; r++) begin : g_crow
        for (genvar c = 0; c < COLS; c++) begin : g_ccol
            localparam int CELL = r * COLS + c;
            localparam int PNW  = r * XCOLS + c;
            logic [NCORNER*LVL_W-1:0] crn_lvl;
            logic [NCORNER-1:0]       crn_en;
            assign crn_lvl[CORNER_NW*LVL_W +: LVL_W] = xp_lvl_c[PNW*LVL_W +: LVL_W];
            assign crn_lvl[CORNER_NE*LVL_W +: LVL_W] = xp_lvl_c[(PNW+1)*LVL_W +: LVL_W];
            assign crn_lvl[CORNER_SW*LVL_W +: LVL_W] = xp_lvl_c[(PNW+XCOLS)*LVL_W +: LVL_W];
            assign crn_lvl[CORNER_SE*LVL_W +: LVL_W] = xp_lvl_c[(PNW+XCOLS+1)*LVL_W +: LVL_W];
            assign crn_en = cfg_q[CELL*CFG_PER + NCORNER +: NCORNER] & {NCORNER{~cfg_en}};
            xnet_sat_adder #(.NIN(NCORNER)) u_rx (
                .lvl_in  (crn_lvl),
                .en_in   (crn_en),
                .lvl_out (rx_lvl_c[CELL*LVL_W +: LVL_W]),
                .ovf_out (rx_ovf_c[CELL])
            );
        end
    end

    // Register all fabric outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xp_lvl <= '0;
            xp_ovf <= '0;
            rx_lvl <= '0;
            rx_ovf <= '0;
        end else begin
            xp_lvl <= xp_lvl_c;
            xp_ovf <= xp_ovf_c;
            rx_lvl <= rx_lvl_c;
            rx_ovf <= rx_ovf_c;
        end
    end
endmodule

// File: rtl/xnet_fabric_chk.sv
// Property checker for xnet_fabric, attached by bind. Assumes synchronous
// active-low reset and observes ports plus the configuration vector.
module xnet_fabric_chk #(
    parameter int NCELL = 9,
    parameter int NXP   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_en,
    input logic [NCELL*8-1:0]   cfg_q,
    input logic [NXP*2-1:0]     xp_lvl,
    input logic [NXP-1:0]       xp_ovf,
    input logic [NCELL*2-1:0]   rx_lvl,
    input logic [NCELL-1:0]     rx_ovf
);
    for (genvar p = 0; p < NXP; p++) begin : g_xp
        // R7
        xp_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            xp_ovf[p] |-> xp_lvl[p*2 +: 2] == 2'd3);
    end

    for (genvar n = 0; n < NCELL; n++) begin : g_rx
        // R9
        rx_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_ovf[n] |-> rx_lvl[n*2 +: 2] == 2'd3);
        // R9
        rx_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[n*8+4 +: 4] == 4'd0) |=> (rx_lvl[n*2 +: 2] == 2'd0 && !rx_ovf[n]));
    end

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));

    // R2
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (xp_lvl == '0 && xp_ovf == '0 && rx_lvl == '0 && rx_ovf == '0));
endmodule

bind xnet_fabric xnet_fabric_chk #(.NCELL(NCELL), .NXP(NXP)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_en (cfg_en),
    .cfg_q  (cfg_q),
    .xp_lvl (xp_lvl),
    .xp_ovf (xp_ovf),
    .rx_lvl (rx_lvl),
    .rx_ovf (rx_ovf)
);

// File: tb/tb_xnet_fabric.sv
`timescale 1ns/1ps
module tb_xnet_fabric;
    localparam int ROWS = 3, COLS = 3;
    localparam int NCELL = ROWS * COLS, NXP = (ROWS + 1) * (COLS + 1);

    logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0;
    logic [NCELL*2-1:0] src_lvl = '0;
    logic [NXP*2-1:0]   xp_lvl;
    logic [NXP-1:0]     xp_ovf;
    logic [NCELL*2-1:0] rx_lvl;
    logic [NCELL-1:0]   rx_ovf;

    int n_chk = 0, n_bad = 0;
    logic [3:0] m_drv [NCELL];
    logic [3:0] m_rd  [NCELL];
    logic [1:0] m_src [NCELL];

    always #2 clk = ~clk;

    xnet_fabric #(.ROWS(ROWS), .COLS(COLS)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .src_lvl(src_lvl), .xp_lvl(xp_lvl), .xp_ovf(xp_ovf),
        .rx_lvl(rx_lvl), .rx_ovf(rx_ovf)
    );

    // Cross-point index of corner k of cell n (R3)
    function automatic int pidx(int n, int k);
        return ((n / COLS) + k / 2) * (COLS + 1) + (n % COLS) + k % 2;
    endfunction

    task automatic cmp(string tag, string what, int idx, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s[%0d] actual=%0d expected=%0d", tag, what, idx, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int n = 0; n < NCELL; n++) begin m_drv[n] = 4'h0; m_rd[n] = 4'h0; m_src[n] = 2'd0; end
    endtask

    // Shift the model configuration in, top bit first (R2)
    task automatic load_cfg();
        logic [NCELL*8-1:0] vec;
        for (int n = 0; n < NCELL; n++) vec[n*8 +: 8] = {m_rd[n], m_drv[n]};
        cfg_en = 1'b1;
        for (int b = NCELL*8-1; b >= 0; b--) begin
            cfg_din = vec[b];
            @(negedge clk);
            if (b == NCELL*8-1) begin
                // R2: switches open during load
                cmp("R2", "xp_lvl_all", 0, int'(xp_lvl != '0), 0);
                cmp("R2", "rx_lvl_all", 0, int'(rx_lvl != '0), 0);
            end
        end
        cfg_en = 1'b0;
    endtask

    // Apply sources, wait one edge, compare everything with the reference (R11)
    task automatic apply_check(string tag);
        int raw_xp [NXP];
        int xl [NXP];
        for (int n = 0; n < NCELL; n++) src_lvl[n*2 +: 2] = m_src[n];
        @(negedge clk);
        for (int p = 0; p < NXP; p++) raw_xp[p] = 0;
        for (int n = 0; n < NCELL; n++)
            for (int k = 0; k < 4; k++)
                if (m_drv[n][k]) raw_xp[pidx(n, k)] += m_src[n];
        for (int p = 0; p < NXP; p++) begin
            xl[p] = raw_xp[p] > 3 ? 3 : raw_xp[p];
            cmp(tag, "xp_lvl", p, xp_lvl[p*2 +: 2], xl[p]);
            cmp(tag, "xp_ovf", p, xp_ovf[p], int'(raw_xp[p] > 3));
        end
        for (int n = 0; n < NCELL; n++) begin
            int s = 0;
            for (int k = 0; k < 4; k++) if (m_rd[n][k]) s += xl[pidx(n, k)];
            cmp(tag, "rx_lvl", n, rx_lvl[n*2 +: 2], s > 3 ? 3 : s);
            cmp(tag, "rx_ovf", n, rx_ovf[n], int'(s > 3));
        end
    endtask

    // R1: reset clears outputs and configuration
    task automatic t_reset();
        src_lvl = '1;
        repeat (3) @(negedge clk);
        cmp("R1", "xp_lvl_all", 0, int'(xp_lvl != '0), 0);
        cmp("R1", "rx_lvl_all", 0, int'(rx_lvl != '0), 0);
        rst_n = 1'b1;
        clear_cfg();
        for (int n = 0; n < NCELL; n++) m_src[n] = 2'd3;
        apply_check("R1");
    endtask

    // R4 R10: cell 0 drives NE, cell 1 reads NW, quaternary levels
    task automatic t_right_transfer();
        clear_cfg();
        m_drv[0] = 4'b0010; m_rd[1] = 4'b0001;
        load_cfg();
        for (int v = 0; v < 4; v++) begin
            m_src[0] = 2'(v);
            apply_check("R4_R10");
            cmp("R10", "rx_lvl", 1, rx_lvl[3:2], v);
        end
    endtask

    // R5 R6: cells 0 and 1 share cross point 5, cell 4 reads it as NW
    task automatic t_merge_sum();
        clear_cfg();
        m_drv[0] = 4'b1000; m_drv[1] = 4'b0100; m_rd[4] = 4'b0001;
        load_cfg();
        for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++) begin
                m_src[0] = 2'(a); m_src[1] = 2'(2 * b);
                apply_check("R5");
                cmp("R5", "rx_lvl", 4, rx_lvl[9:8], a + 2 * b);
                m_src[1] = 2'(b);
                apply_check("R6");
                cmp("R6", "xp_lvl", 5, xp_lvl[11:10], a + b);
            end
    endtask

    // R7: four drivers on one point, exact 3 and excess
    task automatic t_saturate();
        clear_cfg();
        m_drv[0] = 4'b1000; m_drv[1] = 4'b0100; m_drv[3] = 4'b0010; m_drv[4] = 4'b0001;
        load_cfg();
        m_src[0] = 2'd2; m_src[1] = 2'd1;
        apply_check("R7");
        cmp("R7", "xp_ovf", 5, xp_ovf[5], 0);
        m_src[3] = 2'd1;
        apply_check("R7");
        cmp("R7", "xp_ovf", 5, xp_ovf[5], 1);
        for (int n = 0; n < NCELL; n++) m_src[n] = 2'd3;
        apply_check("R7");
        cmp("R7", "xp_lvl", 5, xp_lvl[11:10], 3);
    endtask

    // R8: an undriven source at level 3 adds nothing
    task automatic t_disabled();
        clear_cfg();
        m_drv[1] = 4'b0100; m_rd[4] = 4'b0001;
        load_cfg();
        m_src[0] = 2'd3; m_src[1] = 2'd1; m_src[3] = 2'd3; m_src[4] = 2'd3;
        apply_check("R8");
        cmp("R8", "xp_lvl", 5, xp_lvl[11:10], 1);
    endtask

    // R9: sum formed in the read stage from two different points
    task automatic t_rx_sum();
        clear_cfg();
        m_drv[0] = 4'b1000; m_drv[8] = 4'b0001; m_rd[4] = 4'b1001;
        load_cfg();
        m_src[0] = 2'd1; m_src[8] = 2'd1;
        apply_check("R9");
        cmp("R9", "rx_lvl", 4, rx_lvl[9:8], 2);
        m_src[0] = 2'd2; m_src[8] = 2'd2;
        apply_check("R9");
        cmp("R9", "rx_ovf", 4, rx_ovf[4], 1);
    endtask

    // R3 R2 R11: random enables and levels against the reference sum
    task automatic t_random();
        for (int it = 0; it < 30; it++) begin
            for (int n = 0; n < NCELL; n++) begin
                m_drv[n] = 4'($urandom); m_rd[n] = 4'($urandom);
            end
            load_cfg();
            for (int s = 0; s < 3; s++) begin
                for (int n = 0; n < NCELL; n++) m_src[n] = 2'($urandom);
                apply_check("R3");
            end
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_cfg();
        @(negedge clk);
        t_reset();
        t_right_transfer();
        t_merge_sum();
        t_saturate();
        t_disabled();
        t_rx_sum();
        t_random();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule